// File: doc/BRIEF.md
# Five-Button Press Pulse Generator

This block conditions five mechanical push-buttons (up, left, center, down, right) for use by a synchronous controller. Each raw input is asynchronous and bounces when it is pressed and when it is released. The block turns every real press into one strobe, exactly one clock wide, on that button's own output. Releases, bounce and a button held down for a long time produce no further strobes.

Every channel is built the same way. A two-stage synchronizer brings the raw input into the clock domain. A stability filter then replaces its filtered level with the synchronized value only after that value has disagreed with it for `STABLE_CYCLES` clocks in a row. Last, an edge stage fires on a low-to-high change of the filtered level. The filter counter is `CNT_W` bits wide, and 2^`CNT_W` must be greater than `STABLE_CYCLES`. At a 100 MHz clock, 100 cycles (7 bits) covers bounce under 1 µs, which suits simulation. 1,000,000 cycles (21 bits) covers a 10 ms bounce, which suits hardware.

Top module: `btn_pulse_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all synchronizer stages, filter counters, filtered levels and edge history are cleared, so every `press_*_o` output is low in the cycle after that edge.
- R2: If a raw input is first sampled high at clock edge N and stays high, its press output is high for exactly the one cycle that follows edge N+STABLE_CYCLES+1.
- R3: A press output is never high for two consecutive cycles, and a press held for any length of time (hundreds of thousands of clocks in hardware) gives exactly one strobe.
- R4: The filtered level changes only after the synchronized input has differed from it for STABLE_CYCLES consecutive cycles. Any return to the filtered level before that resets the count to zero, so bursts of STABLE_CYCLES-1 high cycles give no strobe, while exactly STABLE_CYCLES high cycles give one.
- R5: A release (the filtered level going from high to low) gives no strobe.
- R6: Releases are filtered too. After a held press, a low period shorter than STABLE_CYCLES followed by high again gives no second strobe.
- R7: The five channels are independent. Activity on one input never changes another channel's output, and presses on several buttons give one strobe on each, each with its own timing.
- R8: A reset asserted during a press discards any progress of the count. If the input is still held high after reset, the strobe comes STABLE_CYCLES+2 cycles after the first edge with `rst_n` high.
- R9: The synchronized level of each channel equals the raw input as sampled two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_up_i | input | 1 | Raw up button, asynchronous, active high |
| btn_left_i | input | 1 | Raw left button, asynchronous, active high |
| btn_center_i | input | 1 | Raw center button, asynchronous, active high |
| btn_down_i | input | 1 | Raw down button, asynchronous, active high |
| btn_right_i | input | 1 | Raw right button, asynchronous, active high |
| press_up_o | output | 1 | One-cycle strobe per up press |
| press_left_o | output | 1 | One-cycle strobe per left press |
| press_center_o | output | 1 | One-cycle strobe per center press |
| press_down_o | output | 1 | One-cycle strobe per down press |
| press_right_o | output | 1 | One-cycle strobe per down press on the right button |

## Verification
The bench drives bursts one cycle short of the filter window and bursts exactly as long as it. A filter with an off-by-one compare would either strobe on the short burst or miss the exact one, and a filter that failed to restart its count would add the short bursts together and fire early. It also holds a press for far longer than the window, and gives releases that are too short to count followed by a new high. A level detector instead of an edge detector would stream strobes during the hold, and an unfiltered release path would strobe twice. Reset during a press, and presses staggered across channels, expose a count that survives reset and wiring mixed up between channels. Every strobe is checked against a behavioural model in the exact cycle it should appear.

// File: rtl/btn_pulse_pkg.sv
// Package: btn_pulse_pkg
// Shared constants for the button strobe bank: the channel count and the
// bit position of each button inside the internal channel vectors.
// Assumes every module in the bank indexes its vectors with these names.
package btn_pulse_pkg;

    localparam int BTN_COUNT = 5;

    localparam int IDX_UP     = 0;
    localparam int IDX_LEFT   = 1;
    localparam int IDX_CENTER = 2;
    localparam int IDX_DOWN   = 3;
    localparam int IDX_RIGHT  = 4;

endpackage

// File: rtl/btn_sync2.sv
// Module: btn_sync2
// Two-flop synchronizer for one asynchronous level input.
// Assumes the input is a slow level (a switch contact), so losing or adding
// one cycle at a transition does not matter. Reset clears both stages.
module btn_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic meta_q;
    logic stable_q;

    // Shift the raw level through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            stable_q <= 1'b0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;

endmodule

// File: rtl/btn_settle.sv
// Module: btn_settle
// Stability filter. The filtered level takes the input's value only after
// the input has disagreed with it for STABLE_CYCLES consecutive clocks.
// Any agreeing cycle resets the count to zero.
// Assumes 2**CNT_W > STABLE_CYCLES and STABLE_CYCLES >= 1, and that the
// input is already synchronous to clk.
module btn_settle #(
    parameter int STABLE_CYCLES = 100,
    parameter int CNT_W         = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_i,
    output logic             level_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(STABLE_CYCLES - 1);

    logic             level_q;
    logic [CNT_W-1:0] count_q;
    logic             differs;

    assign differs = (level_i != level_q);

    // Count disagreeing cycles, and accept the new level on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            count_q <= '0;
        end else if (!differs) begin
            count_q <= '0;
        end else if (count_q == LAST_COUNT) begin
            level_q <= level_i;
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    assign level_o = level_q;
    assign count_o = count_q;

endmodule

// File: rtl/btn_rise.sv
// Module: btn_rise
// Rising-edge detector. It outputs a one-cycle strobe when the input goes
// from low to high. Assumes a synchronous input. Reset clears the history
// to low, so an input held low through reset gives no strobe.
module btn_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic strobe_o
);

    logic prev_q;

    // Remember last cycle's level for the edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign strobe_o = level_i & ~prev_q;

endmodule

// File: rtl/btn_pulse_bank.sv
// Module: btn_pulse_bank
// Five-button input conditioner. Each channel goes synchronizer, then
// stability filter, then rising-edge detector, and gives one strobe per
// real press. Assumes active-high raw buttons and 2**CNT_W > STABLE_CYCLES.
// Defaults suit simulation. Use 1000000 / 21 for a 10 ms window at 100 MHz.
module btn_pulse_bank #(
    parameter int STABLE_CYCLES = 100,
    parameter int CNT_W         = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_up_i,
    input  logic btn_left_i,
    input  logic btn_center_i,
    input  logic btn_down_i,
    input  logic btn_right_i,
    output logic press_up_o,
    output logic press_left_o,
    output logic press_center_o,
    output logic press_down_o,
    output logic press_right_o
);

    import btn_pulse_pkg::*;

    localparam int N = BTN_COUNT;

    logic [N-1:0]       raw_vec;
    logic [N-1:0]       sync_vec;
    logic [N-1:0]       settled_vec;
    logic [N-1:0]       strobe_vec;
    logic [N*CNT_W-1:0] count_flat;

    // Gather the named buttons into one channel vector.
    always_comb begin
        raw_vec             = '0;
        raw_vec[IDX_UP]     = btn_up_i;
        raw_vec[IDX_LEFT]   = btn_left_i;
        raw_vec[IDX_CENTER] = btn_center_i;
        raw_vec[IDX_DOWN]   = btn_down_i;
        raw_vec[IDX_RIGHT]  = btn_right_i;
    end

    // One identical conditioning chain per button.
    for (genvar ch = 0; ch < N; ch++) begin : g_chan
        btn_sync2 u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (raw_vec[ch]),
            .sync_o  (sync_vec[ch])
        );

        btn_settle #(
            .STABLE_CYCLES (STABLE_CYCLES),
            .CNT_W         (CNT_W)
        ) u_settle (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (sync_vec[ch]),
            .level_o (settled_vec[ch]),
            .count_o (count_flat[ch*CNT_W +: CNT_W])
        );

        btn_rise u_rise (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_i  (settled_vec[ch]),
            .strobe_o (strobe_vec[ch])
        );
    end

    assign press_up_o     = strobe_vec[IDX_UP];
    assign press_left_o   = strobe_vec[IDX_LEFT];
    assign press_center_o = strobe_vec[IDX_CENTER];
    assign press_down_o   = strobe_vec[IDX_DOWN];
    assign press_right_o  = strobe_vec[IDX_RIGHT];

endmodule

// File: rtl/btn_pulse_bank_chk.sv
// Module: btn_pulse_bank_chk
// Assertion checker for btn_pulse_bank, attached with bind. It watches the
// raw, synchronized and filtered levels, the filter counts and the strobes.
module btn_pulse_bank_chk #(
    parameter int N             = 5,
    parameter int STABLE_CYCLES = 100,
    parameter int CNT_W         = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N-1:0]       raw_vec,
    input logic [N-1:0]       sync_vec,
    input logic [N-1:0]       settled_vec,
    input logic [N*CNT_W-1:0] count_flat,
    input logic [N-1:0]       strobe_vec
);

    logic [1:0] age_q;

    // Count edges since reset, saturating at two, to gate the sync check.
    always_ff @(posedge clk) begin
        if (!rst_n)            age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R1: a reset edge leaves every strobe low in the following cycle.
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (strobe_vec == '0));

    for (genvar ch = 0; ch < N; ch++) begin : g_chk
        // R3: a strobe never lasts two cycles.
        assert_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
            strobe_vec[ch] |=> !strobe_vec[ch]);

        // R4: the filter count stays inside its window.
        assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
            count_flat[ch*CNT_W +: CNT_W] < CNT_W'(STABLE_CYCLES));

        // R4: an agreeing cycle restarts the count.
        assert_count_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sync_vec[ch] == settled_vec[ch]) |=> (count_flat[ch*CNT_W +: CNT_W] == '0));

        // R4: the filtered level only moves toward the synchronized value.
        assert_rise_follows_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(settled_vec[ch]) |-> $past(sync_vec[ch]));

        assert_fall_follows_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(settled_vec[ch]) |-> !$past(sync_vec[ch]));

        // R9: the synchronized level lags the raw input by two edges.
        assert_sync_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q == 2'd2) |-> (sync_vec[ch] == $past(raw_vec[ch], 2)));
    end

endmodule

bind btn_pulse_bank btn_pulse_bank_chk #(
    .N             (btn_pulse_pkg::BTN_COUNT),
    .STABLE_CYCLES (STABLE_CYCLES),
    .CNT_W         (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw_vec     (raw_vec),
    .sync_vec    (sync_vec),
    .settled_vec (settled_vec),
    .count_flat  (count_flat),
    .strobe_vec  (strobe_vec)
);

// File: tb/tb_btn_pulse_bank.sv
// Bench for btn_pulse_bank. A behavioural model (a queue per channel for
// the two-edge delay, plus integers) is compared with the DUT on every
// cycle, and directed scenarios check strobe counts and exact timing.
module tb_btn_pulse_bank;

    localparam int DD = 16;
    localparam int KW = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] raw = '0;
    logic [4:0] press;

    int n_checks = 0;
    int n_fail   = 0;
    int seen [5];

    int pipe [5][$];
    int m_cnt [5];
    int m_lvl [5];
    int m_prv [5];

    always #4 clk = ~clk;

    btn_pulse_bank #(.STABLE_CYCLES(DD), .CNT_W(KW)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .btn_up_i       (raw[0]),
        .btn_left_i     (raw[1]),
        .btn_center_i   (raw[2]),
        .btn_down_i     (raw[3]),
        .btn_right_i    (raw[4]),
        .press_up_o     (press[0]),
        .press_left_o   (press[1]),
        .press_center_o (press[2]),
        .press_down_o   (press[3]),
        .press_right_o  (press[4])
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        for (int ch = 0; ch < 5; ch++) begin
            if (!rst_n) begin
                pipe[ch] = {0, 0};
                m_cnt[ch] = 0;
                m_lvl[ch] = 0;
                m_prv[ch] = 0;
            end else begin
                int s;
                s = pipe[ch][0];
                m_prv[ch] = m_lvl[ch];
                if (s != m_lvl[ch]) begin
                    m_cnt[ch]++;
                    if (m_cnt[ch] == DD) begin
                        m_lvl[ch] = s;
                        m_cnt[ch] = 0;
                    end
                end else begin
                    m_cnt[ch] = 0;
                end
                void'(pipe[ch].pop_front());
                pipe[ch].push_back(int'(raw[ch]));
            end
        end
    end

    // Cycle compare (R2 R4 R5 R6 R7 R8 timing) and strobe counting.
    always @(negedge clk) begin
        logic [4:0] exp_v;
        for (int ch = 0; ch < 5; ch++)
            exp_v[ch] = (m_lvl[ch] != 0) && (m_prv[ch] == 0);
        check(press === exp_v, "R2/R4/R5/R6/R7/R8 model compare", int'(press), int'(exp_v));
        for (int ch = 0; ch < 5; ch++)
            if (press[ch]) seen[ch]++;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle_view();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #1500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int ch = 0; ch < 5; ch++) seen[ch] = 0;

        // R1: outputs stay low during and right after reset, even with inputs high.
        raw = 5'b11111;
        cycles(4);
        #1;
        check(press == 5'b0, "R1 during reset", int'(press), 0);
        raw = '0;
        cycles(3);
        @(negedge clk);
        rst_n = 1'b1;
        settle_view();
        check(press == 5'b0, "R1 first cycle after reset", int'(press), 0);
        cycles(DD);

        // R2, R9: a clean up press strobes exactly DD+2 negedges after the drive.
        @(negedge clk);
        raw[0] = 1'b1;
        repeat (DD + 1) settle_view();
        check(press[0] == 1'b0, "R2 no early strobe", int'(press[0]), 0);
        settle_view();
        check(press[0] == 1'b1, "R2 strobe at exact cycle", int'(press[0]), 1);
        settle_view();
        check(press[0] == 1'b0, "R3 strobe one cycle wide", int'(press[0]), 0);

        // R3: long hold gives nothing more.
        cycles(600);
        #1;
        check(seen[0] == 1, "R3 long hold single strobe", seen[0], 1);

        // R5: release gives no strobe.
        raw[0] = 1'b0;
        cycles(3 * DD);
        #1;
        check(seen[0] == 1, "R5 release silent", seen[0], 1);

        // R4: bursts one short of the window never strobe.
        for (int b = 0; b < 5; b++) begin
            @(negedge clk);
            raw[1] = 1'b1;
            cycles(DD - 1);
            raw[1] = 1'b0;
            cycles(1);
        end
        cycles(2 * DD);
        #1;
        check(seen[1] == 0, "R4 short bursts filtered", seen[1], 0);

        // R4: a burst of exactly the window strobes once.
        @(negedge clk);
        raw[1] = 1'b1;
        cycles(DD);
        raw[1] = 1'b0;
        cycles(3 * DD);
        #1;
        check(seen[1] == 1, "R4 exact window accepted", seen[1], 1);

        // R6: a short release gap does not re-arm the edge.
        @(negedge clk);
        raw[2] = 1'b1;
        cycles(2 * DD + 4);
        raw[2] = 1'b0;
        cycles(DD - 1);
        raw[2] = 1'b1;
        cycles(3 * DD);
        #1;
        check(seen[2] == 1, "R6 short release ignored", seen[2], 1);
        raw[2] = 1'b0;
        cycles(2 * DD + 4);

        // R6: a full release followed by a press does strobe again.
        raw[2] = 1'b1;
        cycles(2 * DD + 4);
        #1;
        check(seen[2] == 2, "R6 full release re-arms", seen[2], 2);
        raw[2] = 1'b0;
        cycles(2 * DD + 4);

        // R7: staggered presses on two channels leave the others quiet.
        @(negedge clk);
        raw[3] = 1'b1;
        cycles(3);
        raw[4] = 1'b1;
        cycles(3 * DD);
        #1;
        check(seen[3] == 1, "R7 down single strobe", seen[3], 1);
        check(seen[4] == 1, "R7 right single strobe", seen[4], 1);
        check(seen[0] == 1 && seen[1] == 1 && seen[2] == 2,
              "R7 other channels untouched", seen[0] + seen[1] + seen[2], 4);
        raw[3] = 1'b0;
        raw[4] = 1'b0;
        cycles(2 * DD + 4);

        // R8: reset mid-count discards progress; strobe DD+2 after release.
        @(negedge clk);
        raw[0] = 1'b1;
        cycles(DD / 2 + 2);
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        repeat (DD + 1) settle_view();
        check(press[0] == 1'b0, "R8 no strobe from stale count", int'(press[0]), 0);
        settle_view();
        check(press[0] == 1'b1, "R8 strobe timed from reset release", int'(press[0]), 1);
        cycles(DD);
        #1;
        check(seen[0] == 2, "R8 one strobe for the held press", seen[0], 2);
        raw[0] = 1'b0;
        cycles(2 * DD + 4);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule